// File: doc/BRIEF.md
# Load-Dependence Replay Tracker

This block follows which in-flight loads each speculatively issued instruction depends on, while the scheduler wakes consumers before their producers' latency is known. It holds a bit matrix. Each row is one pipeline stage between issue and load resolution, and each column is one load slot. An issuing instruction gets a dependence vector. That vector is the OR of the vectors of its parents that are still in flight, plus its own column bit if the instruction is itself a load. The rows advance one stage per clock. The matrix depth matches the fixed delay between a load's issue and its hit or miss report, so by the time that report arrives, every consumer of the load is still visible in the matrix.

When a load resolves as a miss, the block computes a replay mask in the same cycle. The mask flags every stage whose instruction depends on that load, directly or through any chain of intermediate instructions. If the instruction issuing in that cycle also depends on the missed load, it is squashed before it enters. On the next edge the flagged rows are dropped and the surviving rows lose that column. When a load resolves as a hit, its column is wiped from every row, so its consumers stop counting as speculative on it. Independent work is never flagged. The scheduler queue, column allocation and the execution units are outside the block.

Top module: `ldt_dep_tracker`

## Requirements
- R1: After reset every stage is empty: `stage_valid`, `stage_dep`, `replay_mask` and `iss_replay` are all zero.
- R2: An accepted issue occupies stage 0 after the next edge and moves one stage per edge. It leaves after stage STAGES-1 unless it is squashed.
- R3: A new row's vector is the OR of the vectors of the parents selected by `src_a_vld`/`src_a_stage` and `src_b_vld`/`src_b_stage` whose stages are valid. An issuing load also sets bit `iss_col`. Row r of `stage_dep` sits at bits [r*LD_COLS +: LD_COLS].
- R4: With `res_kind` = 2'b10 (miss), `replay_mask` bit r is high in the same cycle exactly when stage r is valid and its vector has bit `res_col` set.
- R5: On a miss, rows not flagged keep travelling, and the missed column is cleared from their vectors.
- R6: Rows flagged in `replay_mask` are invalid after the next edge, and no row holds the missed column.
- R7: With `res_kind` = 2'b01 (hit), no replay is raised, and after the next edge the hit column is zero in every row.
- R8: An instruction issuing in a miss cycle whose merged vector contains the missed column raises `iss_replay` in that cycle and does not enter stage 0.
- R9: Dependence is transitive: a consumer of a consumer of a missed load is flagged in the same cycle as the direct consumer.
- R10: When no load resolves, a row's vector is carried unchanged to the next stage.
- R11: `res_kind` = 2'b00 or 2'b11 resolves nothing: no replay, and no column is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_is_load | input | 1 | The issuing instruction is a load |
| iss_col | input | $clog2(LD_COLS) | Load slot column given to an issuing load |
| src_a_vld | input | 1 | First parent is in flight |
| src_a_stage | input | $clog2(STAGES) | Stage currently holding the first parent |
| src_b_vld | input | 1 | Second parent is in flight |
| src_b_stage | input | $clog2(STAGES) | Stage currently holding the second parent |
| res_kind | input | 2 | Load resolution: 00 none, 01 hit, 10 miss, 11 none |
| res_col | input | $clog2(LD_COLS) | Column of the resolving load |
| iss_replay | output | 1 | Issuing instruction squashed by this cycle's miss |
| replay_mask | output | STAGES | Stages whose instructions must be replayed |
| stage_valid | output | STAGES | Occupancy of each stage |
| stage_dep | output | STAGES*LD_COLS | Dependence vector of each stage |

## Verification
`replay_mask` and `iss_replay` are combinational from the current inputs and the matrix. The bench drives inputs on the falling edge and samples these two outputs 1 ns later, before the rising edge. `stage_valid` and `stage_dep` reflect the stimulus one rising edge later, so the bench compares them 1 ns after that edge against a model advanced by exactly one step. Directed sequences pin down the exact values of the squash, merge and hit cases. A long random run then allocates free columns, resolves every load that reaches the bottom stage, and checks every cycle.

// File: rtl/ldt_pkg.sv
package ldt_pkg;

  // Resolution code driven on res_kind
  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_HIT  = 2'b01,
    RES_MISS = 2'b10,
    RES_RSVD = 2'b11
  } res_kind_e;

  localparam int DEF_LD_COLS = 4;
  localparam int DEF_STAGES  = 4;

endpackage

// File: rtl/ldt_reset_sync.sv
module ldt_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/ldt_col_decode.sv
module ldt_col_decode #(
  parameter int LD_COLS = ldt_pkg::DEF_LD_COLS,
  localparam int CW     = $clog2(LD_COLS)
) (
  input  logic [1:0]         res_kind,
  input  logic [CW-1:0]      res_col,
  input  logic               iss_is_load,
  input  logic [CW-1:0]      iss_col,
  output logic [LD_COLS-1:0] hit_oh,
  output logic [LD_COLS-1:0] miss_oh,
  output logic [LD_COLS-1:0] own_oh
);

  logic is_hit;
  logic is_miss;

  always_comb begin
    is_hit  = (res_kind == ldt_pkg::RES_HIT);
    is_miss = (res_kind == ldt_pkg::RES_MISS);
  end

  for (genvar c = 0; c < LD_COLS; c++) begin : g_col
    always_comb begin
      hit_oh[c]  = is_hit  && (res_col == CW'(c));
      miss_oh[c] = is_miss && (res_col == CW'(c));
      own_oh[c]  = iss_is_load && (iss_col == CW'(c));
    end
  end

endmodule

// File: rtl/ldt_src_merge.sv
module ldt_src_merge #(
  parameter int LD_COLS = ldt_pkg::DEF_LD_COLS,
  parameter int STAGES  = ldt_pkg::DEF_STAGES,
  localparam int SW     = $clog2(STAGES),
  localparam int MW     = STAGES * LD_COLS
) (
  input  logic [STAGES-1:0]  row_vld,
  input  logic [MW-1:0]      row_vec,
  input  logic               src_a_vld,
  input  logic [SW-1:0]      src_a_stage,
  input  logic               src_b_vld,
  input  logic [SW-1:0]      src_b_stage,
  input  logic [LD_COLS-1:0] own_oh,
  input  logic [LD_COLS-1:0] hit_oh,
  input  logic [LD_COLS-1:0] miss_oh,
  output logic [LD_COLS-1:0] new_vec,
  output logic               dep_on_miss
);

  logic [LD_COLS-1:0] vec_a;
  logic [LD_COLS-1:0] vec_b;
  logic [LD_COLS-1:0] merged;

  always_comb begin
    vec_a = '0;
    vec_b = '0;
    for (int r = 0; r < STAGES; r++) begin
      if (src_a_vld && row_vld[r] && (src_a_stage == SW'(r))) begin
        vec_a = vec_a | row_vec[r*LD_COLS +: LD_COLS];
      end
      if (src_b_vld && row_vld[r] && (src_b_stage == SW'(r))) begin
        vec_b = vec_b | row_vec[r*LD_COLS +: LD_COLS];
      end
    end
  end

  always_comb begin
    merged      = vec_a | vec_b | own_oh;
    dep_on_miss = |(merged & miss_oh);
    new_vec     = merged & ~(hit_oh | miss_oh);
  end

endmodule

// File: rtl/ldt_stage_row.sv
module ldt_stage_row #(
  parameter int LD_COLS = ldt_pkg::DEF_LD_COLS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic [LD_COLS-1:0] in_vec,
  input  logic [LD_COLS-1:0] miss_oh,
  output logic               q_vld,
  output logic [LD_COLS-1:0] q_vec,
  output logic               replay
);

  logic               load_en;
  logic               nxt_vld;
  logic [LD_COLS-1:0] nxt_vec;

  always_comb begin
    replay  = q_vld && |(q_vec & miss_oh);
    load_en = in_vld || q_vld;
    nxt_vld = in_vld;
    nxt_vec = in_vld ? in_vec : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
      q_vec <= '0;
    end else if (load_en) begin
      q_vld <= nxt_vld;
      q_vec <= nxt_vec;
    end
  end

endmodule

// File: rtl/ldt_dep_tracker.sv
module ldt_dep_tracker #(
  parameter int LD_COLS = ldt_pkg::DEF_LD_COLS,
  parameter int STAGES  = ldt_pkg::DEF_STAGES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          iss_valid,
  input  logic                          iss_is_load,
  input  logic [$clog2(LD_COLS)-1:0]    iss_col,
  input  logic                          src_a_vld,
  input  logic [$clog2(STAGES)-1:0]     src_a_stage,
  input  logic                          src_b_vld,
  input  logic [$clog2(STAGES)-1:0]     src_b_stage,
  input  logic [1:0]                    res_kind,
  input  logic [$clog2(LD_COLS)-1:0]    res_col,
  output logic                          iss_replay,
  output logic [STAGES-1:0]             replay_mask,
  output logic [STAGES-1:0]             stage_valid,
  output logic [STAGES*LD_COLS-1:0]     stage_dep
);

  localparam int MW = STAGES * LD_COLS;

  logic               rst_sync_n;
  logic [LD_COLS-1:0] hit_oh;
  logic [LD_COLS-1:0] miss_oh;
  logic [LD_COLS-1:0] own_oh;
  logic [LD_COLS-1:0] clr_oh;
  logic [LD_COLS-1:0] iss_vec;
  logic               iss_dep_miss;
  logic [STAGES-1:0]  row_in_vld;
  logic [MW-1:0]      row_in_vec;
  logic [STAGES-1:0]  row_q_vld;
  logic [MW-1:0]      row_q_vec;
  logic [STAGES-1:0]  row_replay;

  ldt_reset_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  ldt_col_decode #(.LD_COLS(LD_COLS)) u_dec (
    .res_kind    (res_kind),
    .res_col     (res_col),
    .iss_is_load (iss_is_load),
    .iss_col     (iss_col),
    .hit_oh      (hit_oh),
    .miss_oh     (miss_oh),
    .own_oh      (own_oh)
  );

  ldt_src_merge #(.LD_COLS(LD_COLS), .STAGES(STAGES)) u_merge (
    .row_vld     (row_q_vld),
    .row_vec     (row_q_vec),
    .src_a_vld   (src_a_vld),
    .src_a_stage (src_a_stage),
    .src_b_vld   (src_b_vld),
    .src_b_stage (src_b_stage),
    .own_oh      (own_oh),
    .hit_oh      (hit_oh),
    .miss_oh     (miss_oh),
    .new_vec     (iss_vec),
    .dep_on_miss (iss_dep_miss)
  );

  // A resolving column leaves the matrix on either outcome
  always_comb begin
    clr_oh = hit_oh | miss_oh;
  end

  // Stage 0 takes the issuing instruction unless it is squashed now
  always_comb begin
    row_in_vld[0]         = iss_valid && !iss_dep_miss;
    row_in_vec[LD_COLS-1:0] = (iss_valid && !iss_dep_miss) ? iss_vec : '0;
  end

  // Deeper stages take the survivors of the stage above
  for (genvar r = 1; r < STAGES; r++) begin : g_shift
    always_comb begin
      row_in_vld[r] = row_q_vld[r-1] && !row_replay[r-1];
      row_in_vec[r*LD_COLS +: LD_COLS] = row_in_vld[r]
        ? (row_q_vec[(r-1)*LD_COLS +: LD_COLS] & ~clr_oh)
        : '0;
    end
  end

  for (genvar r = 0; r < STAGES; r++) begin : g_row
    ldt_stage_row #(.LD_COLS(LD_COLS)) u_row (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .in_vld  (row_in_vld[r]),
      .in_vec  (row_in_vec[r*LD_COLS +: LD_COLS]),
      .miss_oh (miss_oh),
      .q_vld   (row_q_vld[r]),
      .q_vec   (row_q_vec[r*LD_COLS +: LD_COLS]),
      .replay  (row_replay[r])
    );
  end

  always_comb begin
    iss_replay  = iss_valid && iss_dep_miss;
    replay_mask = row_replay;
    stage_valid = row_q_vld;
    stage_dep   = row_q_vec;
  end

endmodule

// File: rtl/ldt_dep_tracker_chk.sv
module ldt_dep_tracker_chk #(
  parameter int LD_COLS = ldt_pkg::DEF_LD_COLS,
  parameter int STAGES  = ldt_pkg::DEF_STAGES,
  localparam int CW     = $clog2(LD_COLS),
  localparam int MW     = STAGES * LD_COLS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_replay,
  input logic [1:0]        res_kind,
  input logic [CW-1:0]     res_col,
  input logic [STAGES-1:0] replay_mask,
  input logic [STAGES-1:0] stage_valid,
  input logic [MW-1:0]     stage_dep
);

  function automatic logic col_seen(input logic [MW-1:0] dep, input logic [CW-1:0] col);
    logic seen;
    seen = 1'b0;
    for (int r = 0; r < STAGES; r++) begin
      for (int c = 0; c < LD_COLS; c++) begin
        if (col == CW'(c)) seen = seen | dep[r*LD_COLS + c];
      end
    end
    return seen;
  endfunction

  AST_MASK_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_mask & ~stage_valid) == '0); // R4

  AST_QUIET_NO_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_kind != ldt_pkg::RES_MISS) |-> (replay_mask == '0 && !iss_replay)); // R11

  AST_MISS_COL_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_kind == ldt_pkg::RES_MISS) |=> !col_seen(stage_dep, $past(res_col))); // R6

  AST_HIT_COL_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_kind == ldt_pkg::RES_HIT) |=> !col_seen(stage_dep, $past(res_col))); // R7

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_kind != ldt_pkg::RES_MISS) |=>
      stage_valid[STAGES-1:1] == $past(stage_valid[STAGES-2:0])); // R2

  AST_ISSUE_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_replay) |=> stage_valid[0]); // R2

  AST_SQUASH_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_replay |=> !stage_valid[0]); // R8

  for (genvar r = 0; r < STAGES - 1; r++) begin : g_kill
    AST_KILLED_ROW_GONE: assert property (@(posedge clk) disable iff (!rst_n)
      replay_mask[r] |=> !stage_valid[r+1]); // R6
  end

endmodule

bind ldt_dep_tracker ldt_dep_tracker_chk #(.LD_COLS(LD_COLS), .STAGES(STAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .iss_valid   (iss_valid),
  .iss_replay  (iss_replay),
  .res_kind    (res_kind),
  .res_col     (res_col),
  .replay_mask (replay_mask),
  .stage_valid (stage_valid),
  .stage_dep   (stage_dep)
);

// File: tb/tb_ldt_dep_tracker.sv
`timescale 1ns/1ps
module tb_ldt_dep_tracker;

  localparam int L  = 4;
  localparam int D  = 4;
  localparam int CW = $clog2(L);
  localparam int SW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          iss_valid, iss_is_load, src_a_vld, src_b_vld;
  logic [CW-1:0] iss_col, res_col;
  logic [SW-1:0] src_a_stage, src_b_stage;
  logic [1:0]    res_kind;
  logic          iss_replay;
  logic [D-1:0]  replay_mask, stage_valid;
  logic [D*L-1:0] stage_dep;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  bit         m_vld[D];
  bit [L-1:0] m_vec[D];
  int         m_ld[D];
  bit [D-1:0] last_mask;
  bit         last_iss;

  always #2.5 clk = ~clk;

  ldt_dep_tracker #(.LD_COLS(L), .STAGES(D)) dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_is_load(iss_is_load),
    .iss_col(iss_col), .src_a_vld(src_a_vld), .src_a_stage(src_a_stage),
    .src_b_vld(src_b_vld), .src_b_stage(src_b_stage), .res_kind(res_kind),
    .res_col(res_col), .iss_replay(iss_replay), .replay_mask(replay_mask),
    .stage_valid(stage_valid), .stage_dep(stage_dep)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit [L-1:0] col_bit(input int c);
    bit [L-1:0] v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  function automatic bit [D*L-1:0] model_dep();
    bit [D*L-1:0] f = '0;
    for (int r = 0; r < D; r++) f[r*L +: L] = m_vec[r];
    return f;
  endfunction

  function automatic bit [D-1:0] model_vld();
    bit [D-1:0] f = '0;
    for (int r = 0; r < D; r++) f[r] = m_vld[r];
    return f;
  endfunction

  // One clock of stimulus: inputs at falling edge, combinational check, edge, state check
  task automatic step(input bit v, input bit ld, input int col,
                      input bit av, input int as_, input bit bv, input int bs,
                      input int kind, input int rcol, input string tag);
    bit [L-1:0] hit_oh, miss_oh, merged;
    bit [D-1:0] exp_mask;
    bit         exp_iss;
    bit         n_vld[D];
    bit [L-1:0] n_vec[D];
    int         n_ld[D];
    iss_valid = v; iss_is_load = ld; iss_col = CW'(col);
    src_a_vld = av; src_a_stage = SW'(as_); src_b_vld = bv; src_b_stage = SW'(bs);
    res_kind = 2'(kind); res_col = CW'(rcol);
    #1;
    hit_oh  = (kind == 1) ? col_bit(rcol) : '0;
    miss_oh = (kind == 2) ? col_bit(rcol) : '0;
    merged  = '0;
    if (av && m_vld[as_]) merged |= m_vec[as_];
    if (bv && m_vld[bs])  merged |= m_vec[bs];
    if (ld) merged |= col_bit(col);
    exp_iss = v && |(merged & miss_oh);
    for (int r = 0; r < D; r++) exp_mask[r] = m_vld[r] && |(m_vec[r] & miss_oh);
    last_mask = replay_mask;
    last_iss  = iss_replay;
    chk(replay_mask == exp_mask, {tag, " R4"}, "replay_mask", replay_mask, exp_mask);
    chk(iss_replay == exp_iss, {tag, " R8"}, "iss_replay", iss_replay, exp_iss);
    for (int r = D - 1; r >= 1; r--) begin
      n_vld[r] = m_vld[r-1] && !exp_mask[r-1];
      n_vec[r] = n_vld[r] ? (m_vec[r-1] & ~(hit_oh | miss_oh)) : '0;
      n_ld[r]  = n_vld[r] ? m_ld[r-1] : -1;
    end
    n_vld[0] = v && !exp_iss;
    n_vec[0] = n_vld[0] ? (merged & ~(hit_oh | miss_oh)) : '0;
    n_ld[0]  = (n_vld[0] && ld) ? col : -1;
    @(posedge clk);
    #1;
    for (int r = 0; r < D; r++) begin
      m_vld[r] = n_vld[r]; m_vec[r] = n_vec[r]; m_ld[r] = n_ld[r];
    end
    chk(stage_valid == model_vld(), {tag, " R2"}, "stage_valid", stage_valid, model_vld());
    chk(stage_dep == model_dep(), {tag, " R5"}, "stage_dep", stage_dep, model_dep());
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7121));
    for (int r = 0; r < D; r++) begin m_vld[r] = 0; m_vec[r] = '0; m_ld[r] = -1; end
    rst_n = 1'b0;
    iss_valid = 0; iss_is_load = 0; iss_col = '0; src_a_vld = 0; src_a_stage = '0;
    src_b_vld = 0; src_b_stage = '0; res_kind = '0; res_col = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(stage_valid == '0, "R1", "stage_valid", stage_valid, 0);
    chk(stage_dep == '0, "R1", "stage_dep", stage_dep, 0);
    chk(replay_mask == '0 && !iss_replay, "R1", "replay", replay_mask, 0);
    @(negedge clk);

    // R2: one instruction walks the stages and leaves
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "walk");
    chk(stage_valid == 4'b0001, "R2", "walk s0", stage_valid, 4'b0001);
    idle("walk"); chk(stage_valid == 4'b0010, "R2", "walk s1", stage_valid, 4'b0010);
    idle("walk"); chk(stage_valid == 4'b0100, "R2", "walk s2", stage_valid, 4'b0100);
    idle("walk"); chk(stage_valid == 4'b1000, "R2", "walk s3", stage_valid, 4'b1000);
    idle("walk"); chk(stage_valid == 4'b0000, "R2", "walk out", stage_valid, 0);

    // R9 / R4 / R5 / R6 / R8: chain load0 -> child -> grandchild, plus an independent
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, "chain");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "chain");
    step(1, 0, 0, 1, 1, 0, 0, 0, 0, "chain");
    step(1, 0, 0, 1, 0, 1, 1, 0, 0, "chain");
    chk(stage_dep == 16'h1011, "R9", "chain vectors", stage_dep, 16'h1011);
    step(1, 0, 0, 1, 0, 0, 0, 2, 0, "miss");
    chk(last_mask == 4'b1011, "R9", "transitive replay_mask", last_mask, 4'b1011);
    chk(last_iss == 1'b1, "R8", "issuing dependent squashed", last_iss, 1);
    chk(stage_valid == 4'b1000, "R6", "flagged rows dropped", stage_valid, 4'b1000);
    chk(stage_dep == 16'h0000, "R5", "independent survives clean", stage_dep, 0);
    repeat (2) idle("drain");

    // R3: two-parent merge plus own load bit
    step(1, 1, 1, 0, 0, 0, 0, 0, 0, "merge");
    step(1, 1, 2, 1, 0, 0, 0, 0, 0, "merge");
    chk(stage_dep[3:0] == 4'b0110, "R3", "load with parent", stage_dep[3:0], 4'b0110);
    step(1, 1, 3, 0, 0, 0, 0, 0, 0, "merge");
    step(1, 0, 0, 1, 0, 1, 1, 0, 0, "merge");
    chk(stage_dep[3:0] == 4'b1110, "R3", "two-parent OR", stage_dep[3:0], 4'b1110);

    // R7: hit on column 1
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, "hit");
    chk(last_mask == '0 && !last_iss, "R7", "hit raises no replay", last_mask, 0);
    chk(stage_dep == 16'h48C0, "R7", "hit column wiped", stage_dep, 16'h48C0);
    chk(stage_valid == 4'b1110, "R7", "hit keeps rows", stage_valid, 4'b1110);

    // R10: no resolution carries vectors unchanged
    idle("carry");
    chk(stage_dep == 16'h8C00, "R10", "vectors carried", stage_dep, 16'h8C00);

    // R11: reserved code resolves nothing
    step(0, 0, 0, 0, 0, 0, 0, 3, 3, "rsvd");
    chk(last_mask == '0, "R11", "reserved code no replay", last_mask, 0);
    chk(stage_dep == 16'hC000, "R11", "reserved code clears nothing", stage_dep, 16'hC000);
    repeat (2) idle("drain");

    // Random traffic with column allocation and bottom-stage resolution
    for (int n = 0; n < 4000; n++) begin
      bit v, ld, av, bv;
      int col, kind, rcol, as_, bs;
      bit [L-1:0] busy;
      busy = '0;
      for (int r = 0; r < D; r++) if (m_vld[r] && m_ld[r] >= 0) busy[m_ld[r]] = 1'b1;
      kind = 0; rcol = int'($urandom_range(L - 1));
      if (m_vld[D-1] && m_ld[D-1] >= 0) begin
        kind = ($urandom_range(3) == 0) ? 2 : 1;
        rcol = m_ld[D-1];
      end else if ($urandom_range(9) == 0) begin
        kind = 3;
      end
      v   = ($urandom_range(9) < 7);
      av  = $urandom_range(1); as_ = int'($urandom_range(D - 1));
      bv  = $urandom_range(1); bs  = int'($urandom_range(D - 1));
      ld  = 0; col = 0;
      if (v && busy != '1 && $urandom_range(4) < 2) begin
        ld = 1;
        do col = int'($urandom_range(L - 1)); while (busy[col]);
      end
      step(v, ld, col, av, as_, bv, bs, kind, rcol, "random R3");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule